// File: doc/BRIEF.md
# Virtual Clock Packet Scheduler

This block orders packet descriptors from several flows so that each flow is served as if it sent at its reserved rate. Every flow has two state items: a cost per bit (the inverse of its reserved rate) and a running virtual transmission time. An arriving descriptor carries a flow index and a length in bits. The block then moves that flow's virtual time forward, starting from whichever is later, the stored virtual time or the wall-clock time supplied at the `wall_time` input. The step is the length multiplied by the flow's cost. The new value is stored as the descriptor's stamp, and the descriptor goes into a small buffer.

A dequeue request releases the buffered descriptor with the smallest stamp. Two things follow from taking the later of the stored time and the arrival time. A flow that was idle cannot bank credit. A flow that got more than its share while others were idle keeps its far-future virtual time, so newer arrivals from other flows overtake it. Wall time and stamps are unsigned counts of the same tick. The cost per bit is a fixed-point number of ticks with 10 fraction bits. Flow count, widths and buffer depth are parameters in the shared package. The reset input is asynchronous, active low, and is released in step with the clock.

Top module: `vclk_sched`

## Requirements
- R1: After reset, `empty` is 1 and `full` and `deq_valid` are 0. Every flow's virtual time is zero, so a flow's first packet at wall time 0 is stamped with exactly its own increment.
- R2: An accepted arrival of flow f with length L at wall time w gets stamp max(V[f], w) + floor(L * C[f] / 1024). V[f] is the stored virtual time of flow f and C[f] is its `cfg_cost`. V[f] then becomes that stamp.
- R3: With a cost of 3072 (3 ticks per bit) and 1000-bit packets, back-to-back packets of one flow arriving at wall time 0 get stamps 3000, 6000, 9000 and 12000.
- R4: A flow that returns after idling, at a wall time later than its stored virtual time, gets a stamp equal to its arrival time plus one increment. It gets no earlier stamp. Every accepted stamp is at least the arrival wall time.
- R5: A flow served above its rate while others were idle keeps its advanced virtual time. A later arrival from another flow with a smaller stamp is dequeued before it.
- R6: A dequeue releases the buffered descriptor with the smallest stamp. On equal stamps the lower flow index goes first. Within one flow, equal stamps leave in arrival order.
- R7: `deq_valid` and the descriptor fields appear one cycle after the edge that samples `deq_req`. A request while `empty` is 1 produces no `deq_valid`.
- R8: The buffer holds 16 descriptors and `full` is 1 when all 16 are held. An arrival while `full` is 1 is dropped and leaves that flow's virtual time unchanged.
- R9: An arrival and a dequeue in the same cycle both take effect. The arriving descriptor is not a candidate for that same dequeue, even if its stamp is smallest.
- R10: A `cfg_we` write sets the cost of flow `cfg_flow`. Later arrivals of that flow use the new cost, and already buffered stamps do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for a flow cost |
| cfg_flow | input | 2 | Flow whose cost is written |
| cfg_cost | input | 16 | Ticks per bit, 10 fraction bits |
| wall_time | input | 32 | Free-running wall-clock time in ticks |
| arr_valid | input | 1 | Descriptor arrival strobe |
| arr_flow | input | 2 | Flow index of the arrival |
| arr_len | input | 16 | Packet length in bits |
| deq_req | input | 1 | Request to release the smallest-stamp descriptor |
| deq_valid | output | 1 | Released descriptor is on the outputs |
| deq_flow | output | 2 | Flow of the released descriptor |
| deq_len | output | 16 | Length of the released descriptor |
| deq_stamp | output | 32 | Stamp of the released descriptor |
| full | output | 1 | All 16 entries occupied |
| empty | output | 1 | No entry occupied |

## Verification
The bench uses the package defaults: four flows, a 16-entry buffer, 32-bit time and 16-bit costs with 10 fraction bits. Four flows are enough to produce three-way ties on one stamp and to check the flow-index tie break across them. A depth of 16 is small enough that the bench fills the buffer completely, checks that a dropped arrival leaves no trace in its flow's virtual time, and then drains every entry. A cost of 1536 makes the floor in the increment visible. A cost of zero produces equal stamps inside one flow, which exposes the arrival-order rule.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int NUM_FLOWS = 4;
  localparam int FLOW_W    = $clog2(NUM_FLOWS);
  localparam int LEN_W     = 16;
  localparam int TIME_W    = 32;
  localparam int COST_W    = 16;
  localparam int COST_FRAC = 10;
  localparam int DEPTH     = 16;
  localparam int IDX_W     = $clog2(DEPTH);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int PROD_W    = LEN_W + COST_W;
  localparam int INC_W     = PROD_W - COST_FRAC;

  typedef struct packed {
    logic [TIME_W-1:0] stamp;
    logic [FLOW_W-1:0] flow;
    logic [LEN_W-1:0]  len;
  } desc_t;
endpackage

// File: rtl/vclk_rst_sync.sv
module vclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/vclk_flow_state.sv
module vclk_flow_state
  import vclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              cfg_we,
  input  logic [FLOW_W-1:0] cfg_flow,
  input  logic [COST_W-1:0] cfg_cost,
  input  logic [FLOW_W-1:0] arr_flow,
  input  logic [LEN_W-1:0]  arr_len,
  input  logic [TIME_W-1:0] wall_time,
  input  logic              upd_en,
  output logic [TIME_W-1:0] stamp
);
  logic [TIME_W-1:0] vt_q   [NUM_FLOWS];
  logic [COST_W-1:0] cost_q [NUM_FLOWS];
  logic [TIME_W-1:0] base;
  logic [PROD_W-1:0] prod;
  logic [INC_W-1:0]  inc;

  // stamp arithmetic: later of stored time and wall time, plus len*cost
  always_comb begin
    base  = (vt_q[arr_flow] > wall_time) ? vt_q[arr_flow] : wall_time;
    prod  = PROD_W'(arr_len) * PROD_W'(cost_q[arr_flow]);
    inc   = prod[PROD_W-1:COST_FRAC];
    stamp = base + TIME_W'(inc);
  end

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
    logic vt_en;
    logic cost_en;

    always_comb begin
      vt_en   = upd_en && (arr_flow == FLOW_W'(g));
      cost_en = cfg_we && (cfg_flow == FLOW_W'(g));
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        vt_q[g]   <= '0;
        cost_q[g] <= '0;
      end else begin
        if (vt_en)   vt_q[g]   <= stamp;
        if (cost_en) cost_q[g] <= cfg_cost;
      end
    end
  end
endmodule

// File: rtl/vclk_min_sel.sv
module vclk_min_sel
  import vclk_pkg::*;
(
  input  desc_t             slots [DEPTH],
  input  logic [CNT_W-1:0]  count,
  output logic [IDX_W-1:0]  min_idx
);
  function automatic logic precedes(input desc_t a, input desc_t b);
    return (a.stamp < b.stamp) || ((a.stamp == b.stamp) && (a.flow < b.flow));
  endfunction

  logic found;

  // slots are kept in arrival order; strict compare keeps the older on ties
  always_comb begin
    min_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < count) begin
        if (!found || precedes(slots[i], slots[min_idx])) begin
          min_idx = IDX_W'(i);
          found   = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vclk_store.sv
module vclk_store
  import vclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ns,
  input  logic             push,
  input  desc_t            push_desc,
  input  logic             pop,
  output desc_t            head,
  output logic [CNT_W-1:0] count
);
  desc_t            slot_q [DEPTH];
  desc_t            slot_d [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] ins_pos;
  logic [IDX_W-1:0] head_idx;
  logic             slot_en;

  vclk_min_sel u_min (
    .slots   (slot_q),
    .count   (cnt_q),
    .min_idx (head_idx)
  );

  always_comb begin
    ins_pos = cnt_q - (pop ? CNT_W'(1) : CNT_W'(0));
    cnt_d   = cnt_q + (push ? CNT_W'(1) : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    slot_en = push || pop;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    desc_t shifted;
    if (g + 1 < DEPTH) begin : g_mid
      always_comb shifted = (pop && (IDX_W'(g) >= head_idx)) ? slot_q[g+1] : slot_q[g];
    end else begin : g_top
      always_comb shifted = slot_q[g];
    end

    always_comb begin
      slot_d[g] = (push && (ins_pos == CNT_W'(g))) ? push_desc : shifted;
    end

    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= slot_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign head  = slot_q[head_idx];
  assign count = cnt_q;
endmodule

// File: rtl/vclk_sched.sv
module vclk_sched
  import vclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [FLOW_W-1:0] cfg_flow,
  input  logic [COST_W-1:0] cfg_cost,
  input  logic [TIME_W-1:0] wall_time,
  input  logic              arr_valid,
  input  logic [FLOW_W-1:0] arr_flow,
  input  logic [LEN_W-1:0]  arr_len,
  input  logic              deq_req,
  output logic              deq_valid,
  output logic [FLOW_W-1:0] deq_flow,
  output logic [LEN_W-1:0]  deq_len,
  output logic [TIME_W-1:0] deq_stamp,
  output logic              full,
  output logic              empty
);
  logic             rst_ns;
  logic [CNT_W-1:0] count;
  logic             accept;
  logic             pop;
  logic [TIME_W-1:0] new_stamp;
  desc_t            push_desc;
  desc_t            head;
  desc_t            out_q;
  logic             deq_valid_q;
  logic             deq_valid_d;

  vclk_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    full        = (count == CNT_W'(DEPTH));
    empty       = (count == '0);
    accept      = arr_valid && !full;
    pop         = deq_req && !empty;
    deq_valid_d = pop;
    push_desc   = '{stamp: new_stamp, flow: arr_flow, len: arr_len};
  end

  vclk_flow_state u_flow (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .cfg_we    (cfg_we),
    .cfg_flow  (cfg_flow),
    .cfg_cost  (cfg_cost),
    .arr_flow  (arr_flow),
    .arr_len   (arr_len),
    .wall_time (wall_time),
    .upd_en    (accept),
    .stamp     (new_stamp)
  );

  vclk_store u_store (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .push      (accept),
    .push_desc (push_desc),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) deq_valid_q <= 1'b0;
    else         deq_valid_q <= deq_valid_d;
  end

  always_ff @(posedge clk) begin
    if (pop) out_q <= head;
  end

  assign deq_valid = deq_valid_q;
  assign deq_flow  = out_q.flow;
  assign deq_len   = out_q.len;
  assign deq_stamp = out_q.stamp;
endmodule

// File: rtl/vclk_sched_chk.sv
module vclk_sched_chk
  import vclk_pkg::*;
(
  input logic              clk,
  input logic              rst_ns,
  input logic [CNT_W-1:0]  count,
  input logic              full,
  input logic              empty,
  input logic              arr_valid,
  input logic              deq_req,
  input logic              deq_valid,
  input logic [TIME_W-1:0] wall_time,
  input logic [TIME_W-1:0] new_stamp
);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    count <= CNT_W'(DEPTH));

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (full && arr_valid && !deq_req) |=> full);

  assert_deq_cause_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    deq_valid |-> ($past(deq_req) && !$past(empty)));

  assert_empty_req_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    (deq_req && empty) |=> !deq_valid);

  assert_stamp_floor_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (arr_valid && !full) |-> (new_stamp >= wall_time));

  assert_both_act_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (arr_valid && !full && deq_req && !empty) |=> $stable(count));
endmodule

bind vclk_sched vclk_sched_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .count     (count),
  .full      (full),
  .empty     (empty),
  .arr_valid (arr_valid),
  .deq_req   (deq_req),
  .deq_valid (deq_valid),
  .wall_time (wall_time),
  .new_stamp (new_stamp)
);

// File: tb/vclk_sched_tb.sv
`timescale 1ns/1ps
module vclk_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_flow;
  logic [15:0] cfg_cost;
  logic [31:0] wall_time;
  logic        arr_valid;
  logic [1:0]  arr_flow;
  logic [15:0] arr_len;
  logic        deq_req;
  logic        deq_valid;
  logic [1:0]  deq_flow;
  logic [15:0] deq_len;
  logic [31:0] deq_stamp;
  logic        full;
  logic        empty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vclk_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flow(cfg_flow),
    .cfg_cost(cfg_cost), .wall_time(wall_time), .arr_valid(arr_valid),
    .arr_flow(arr_flow), .arr_len(arr_len), .deq_req(deq_req),
    .deq_valid(deq_valid), .deq_flow(deq_flow), .deq_len(deq_len),
    .deq_stamp(deq_stamp), .full(full), .empty(empty)
  );

  // {flow[81:80], len[79:64], wall[63:32], expected stamp[31:0]}
  localparam logic [81:0] VEC [10] = '{
    {2'd0, 16'd1000, 32'd0,     32'd3000 },  // R3
    {2'd0, 16'd1000, 32'd0,     32'd6000 },  // R3
    {2'd0, 16'd1000, 32'd10,    32'd9000 },  // R3
    {2'd0, 16'd1000, 32'd20,    32'd12000},  // R3
    {2'd1, 16'd100,  32'd50,    32'd150  },  // R2
    {2'd2, 16'd10,   32'd60,    32'd75   },  // R2
    {2'd2, 16'd3,    32'd60,    32'd79   },  // R2 floor of 4.5
    {2'd1, 16'd100,  32'd1000,  32'd1100 },  // R4
    {2'd0, 16'd1000, 32'd20000, 32'd23000},  // R4
    {2'd3, 16'd0,    32'd500,   32'd500  }   // R2 zero length
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int f, input int c);
    cfg_we = 1'b1; cfg_flow = 2'(f); cfg_cost = 16'(c);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cfg(0, 3072); cfg(1, 1024); cfg(2, 1536); cfg(3, 3072);
  endtask

  task automatic push(input int f, input int l, input int w);
    arr_valid = 1'b1; arr_flow = 2'(f); arr_len = 16'(l); wall_time = 32'(w);
    @(negedge clk);
    arr_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input int ef, input int el, input longint es);
    deq_req = 1'b1;
    @(negedge clk);
    deq_req = 1'b0;
    check(deq_valid == 1'b1, req, "deq_valid", longint'(deq_valid), 1);
    check(deq_flow == 2'(ef), req, "deq_flow", longint'(deq_flow), ef);
    if (el >= 0) check(deq_len == 16'(el), req, "deq_len", longint'(deq_len), el);
    check(deq_stamp == 32'(es), req, "deq_stamp", longint'(deq_stamp), es);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_flow = '0; cfg_cost = '0; wall_time = '0;
    arr_valid = 1'b0; arr_flow = '0; arr_len = '0; deq_req = 1'b0;
    do_reset();

    // R1 reset state
    check(empty == 1'b1, "R1", "empty", longint'(empty), 1);
    check(full == 1'b0, "R1", "full", longint'(full), 0);
    check(deq_valid == 1'b0, "R1", "deq_valid", longint'(deq_valid), 0);

    // R7 request on empty store
    deq_req = 1'b1;
    @(negedge clk);
    deq_req = 1'b0;
    check(deq_valid == 1'b0, "R7", "deq_valid on empty", longint'(deq_valid), 0);

    // vector table: arrive then release, store empty each time
    for (int i = 0; i < 10; i++) begin
      push(int'(VEC[i][81:80]), int'(VEC[i][79:64]), int'(VEC[i][63:32]));
      pop_chk("R2/R3/R4 table", int'(VEC[i][81:80]), int'(VEC[i][79:64]),
              longint'(VEC[i][31:0]));
    end

    // R1 virtual times cleared by reset
    do_reset();
    push(0, 1000, 0);
    pop_chk("R1 vt cleared", 0, 1000, 3000);

    // R6 ordering with ties across flows
    do_reset();
    push(1, 3000, 0);
    push(0, 1000, 0);
    push(3, 1000, 0);
    push(2, 10, 0);
    push(0, 1000, 0);
    pop_chk("R6", 2, 10, 15);
    pop_chk("R6", 0, 1000, 3000);
    pop_chk("R6", 1, 3000, 3000);
    pop_chk("R6", 3, 1000, 3000);
    pop_chk("R6", 0, 1000, 6000);

    // R10 new cost, R6 arrival order within a flow
    cfg(3, 0);
    push(3, 7, 100);
    push(3, 9, 100);
    pop_chk("R10/R6 same flow", 3, 7, 3000);
    pop_chk("R10/R6 same flow", 3, 9, 3000);
    push(3, 5, 4000);
    pop_chk("R10 zero cost", 3, 5, 4000);

    // R5 penalty for a flow that ran ahead
    do_reset();
    for (int k = 0; k < 4; k++) push(0, 1000, 0);
    pop_chk("R5", 0, 1000, 3000);
    pop_chk("R5", 0, 1000, 6000);
    pop_chk("R5", 0, 1000, 9000);
    pop_chk("R5", 0, 1000, 12000);
    push(0, 1000, 8000);
    push(3, 1000, 8000);
    pop_chk("R5", 3, 1000, 11000);
    pop_chk("R5", 0, 1000, 15000);

    // R8 fill, drop, drain
    do_reset();
    for (int k = 0; k < 16; k++) push(1, 1, 0);
    check(full == 1'b1, "R8", "full", longint'(full), 1);
    push(1, 1, 0);
    check(full == 1'b1, "R8", "full after drop", longint'(full), 1);
    for (int k = 1; k <= 16; k++) pop_chk("R8 drain", 1, 1, longint'(k));
    check(empty == 1'b1, "R8", "empty after drain", longint'(empty), 1);
    push(1, 1, 0);
    pop_chk("R8 drop kept vt", 1, 1, 17);

    // R9 simultaneous arrival and dequeue
    do_reset();
    push(0, 1000, 0);
    arr_valid = 1'b1; arr_flow = 2'd2; arr_len = 16'd10; wall_time = 32'd0;
    deq_req = 1'b1;
    @(negedge clk);
    arr_valid = 1'b0; deq_req = 1'b0;
    check(deq_valid == 1'b1, "R9", "deq_valid", longint'(deq_valid), 1);
    check(deq_stamp == 32'd3000, "R9", "old entry released", longint'(deq_stamp), 3000);
    check(empty == 1'b0, "R9", "new entry held", longint'(empty), 0);
    pop_chk("R9", 2, 10, 15);
    check(empty == 1'b1, "R9", "empty", longint'(empty), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule